// File: doc/BRIEF.md
# Multi-channel interrupt fan-out multiplexer

The block gathers a bank of active-high, level-sensitive interrupt sources and presents them on a small number of output channels. Every source is wired to every channel, and each channel holds its own enable mask over the whole source bank. One source can therefore be steered to any subset of the outputs. A channel output is raised, one clock after the condition appears, whenever at least one source that the channel enables is high. It stays raised for as long as that condition holds.

Software reaches the block through a small memory-mapped register port. A request carries a write flag, a byte address and write data. Each channel has a read/write enable register and a read-only pending register, which shows the enabled sources that are asserting right now. An interrupt service routine reads the pending register of the channel that fired to find its causes. It masks or unmasks a single source with a read-modify-write of the enable register.

Top module: `irq_fanout_mux`

## Requirements
- R1: After reset every enable register reads 0, every channel output is low and `bus_rvalid` is low.
- R2: Every source reaches every channel. Channel n's output is high exactly when some source k is high while bit k of channel n's enable register is set, so one source may drive several channels at once.
- R3: Channel n's enable register is at byte address 0x10 + 0x40·n. Bit k enables source k on that channel, and a read returns exactly the value last written.
- R4: Channel n's pending register is at byte address 0x20 + 0x40·n. A read returns the bitwise AND of the source inputs and that channel's enable register, both taken in the cycle of the request.
- R5: A channel output is registered. It changes on the first clock edge after its sources or enables change, and it stays high for as long as an enabled source stays high.
- R6: Writing 0 to a channel's enable register disables all of its sources, and its output is low from the second clock edge after the write.
- R7: The pending registers are read-only. A write to one changes no enable register and no output.
- R8: Byte addresses that match no register read as 0, and writes to them have no effect. This includes addresses of 0x200 and above and addresses with nonzero bits 1:0.
- R9: Every read request, mapped or not, gives `bus_rvalid` high on the clock edge that follows it, with `bus_rdata` valid in that same cycle. A write request never raises `bus_rvalid`.
- R10: `NUM_CH` (at most 8) sets the number of channels. The register addresses of channel indices from `NUM_CH` to 7 act as unmapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | NUM_SRC | Level-sensitive interrupt sources, active high |
| bus_req | input | 1 | Register access request, valid for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Read data, valid while `bus_rvalid` is high |
| bus_rvalid | output | 1 | Read response strobe |
| chan_irq | output | NUM_CH | One interrupt output per channel |

## Verification
The assertions check on every cycle that a read request is answered on the next cycle and that a write never is. They check that enable and pending reads return the enable state and the masked sources seen at the request, and that pending or unmapped writes and unmapped reads leave no trace. They also check that an output never rises without a source or with an empty mask. Only the bench scenarios can show that one source drives several channels at once, that an output holds through a long level, and that masks built from random write sequences keep matching the outputs. The same goes for a channel index at or beyond the channel count, which the bench maps to nothing.

// File: rtl/irqmux_pkg.sv
package irqmux_pkg;
  localparam int unsigned MAX_CH    = 8;
  localparam int unsigned CH_IDX_W  = 3;
  localparam int unsigned STRIDE_LSB = 6;   // 0x40-byte bank stride
  localparam logic [5:0]  OFS_ENABLE  = 6'h10;
  localparam logic [5:0]  OFS_PENDING = 6'h20;
  localparam int unsigned MAP_TOP_LSB = STRIDE_LSB + CH_IDX_W;

  typedef enum logic [1:0] {
    KIND_NONE    = 2'd0,
    KIND_ENABLE  = 2'd1,
    KIND_PENDING = 2'd2
  } reg_kind_e;
endpackage

// File: rtl/irqmux_decode.sv
module irqmux_decode
  import irqmux_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0]   addr,
  output reg_kind_e           kind,
  output logic [CH_IDX_W-1:0] ch
);
  logic [5:0] ofs;
  logic       upper_clear;
  logic       ch_exists;

  assign ofs = addr[STRIDE_LSB-1:0];
  assign ch  = addr[MAP_TOP_LSB-1:STRIDE_LSB];

  generate
    if (ADDR_W > MAP_TOP_LSB) begin : g_upper
      assign upper_clear = (addr[ADDR_W-1:MAP_TOP_LSB] == '0);
    end else begin : g_no_upper
      assign upper_clear = 1'b1;
    end
  endgenerate

  assign ch_exists = ({1'b0, ch} < (CH_IDX_W+1)'(NUM_CH));

  always_comb begin
    kind = KIND_NONE;
    if (upper_clear && ch_exists) begin
      if (ofs == OFS_ENABLE)       kind = KIND_ENABLE;
      else if (ofs == OFS_PENDING) kind = KIND_PENDING;
    end
  end
endmodule

// File: rtl/irqmux_channel.sv
module irqmux_channel #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_wr,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic [NUM_SRC-1:0] src,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] pend,
  output logic               irq_q
);
  logic [NUM_SRC-1:0] en_d;
  logic               irq_d;

  assign pend = src & en_q;

  always_comb begin
    en_d  = en_q;
    if (en_wr) en_d = wdata;
    irq_d = |pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (en_wr) en_q <= en_d;
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/irqmux_rdport.sv
module irqmux_rdport
  import irqmux_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned NUM_SRC = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd_req,
  input  reg_kind_e                       kind,
  input  logic [CH_IDX_W-1:0]             ch,
  input  logic [NUM_CH-1:0][NUM_SRC-1:0]  en_all,
  input  logic [NUM_CH-1:0][NUM_SRC-1:0]  pend_all,
  output logic [NUM_SRC-1:0]              rdata_q,
  output logic                            rvalid_q
);
  logic [NUM_SRC-1:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch == CH_IDX_W'(i)) begin
        if (kind == KIND_ENABLE)  rdata_d = en_all[i];
        if (kind == KIND_PENDING) rdata_d = pend_all[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) rdata_q <= rdata_d;
    end
  end
endmodule

// File: rtl/irq_fanout_mux.sv
module irq_fanout_mux
  import irqmux_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  output logic               bus_rvalid,
  output logic [NUM_CH-1:0]  chan_irq
);
  logic [1:0]                     rst_pipe;
  logic                           rst_sync_n;
  reg_kind_e                      kind;
  logic [CH_IDX_W-1:0]            ch;
  logic [NUM_CH-1:0][NUM_SRC-1:0] en_all;
  logic [NUM_CH-1:0][NUM_SRC-1:0] pend_all;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  irqmux_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .kind (kind),
    .ch   (ch)
  );

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      logic wr_hit;
      assign wr_hit = bus_req && bus_we && (kind == KIND_ENABLE) && (ch == CH_IDX_W'(n));
      irqmux_channel #(.NUM_SRC(NUM_SRC)) u_channel (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .en_wr (wr_hit),
        .wdata (bus_wdata),
        .src   (src_irq),
        .en_q  (en_all[n]),
        .pend  (pend_all[n]),
        .irq_q (chan_irq[n])
      );
    end
  endgenerate

  irqmux_rdport #(.NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC)) u_rdport (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_req   (bus_req && !bus_we),
    .kind     (kind),
    .ch       (ch),
    .en_all   (en_all),
    .pend_all (pend_all),
    .rdata_q  (bus_rdata),
    .rvalid_q (bus_rvalid)
  );
endmodule

// File: rtl/irqmux_checker.sv
module irqmux_checker #(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 12
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [NUM_SRC-1:0]              src_irq,
  input logic                            bus_req,
  input logic                            bus_we,
  input logic [ADDR_W-1:0]               bus_addr,
  input logic [NUM_SRC-1:0]              bus_rdata,
  input logic                            bus_rvalid,
  input logic [NUM_CH-1:0]               chan_irq,
  input logic [NUM_CH-1:0][NUM_SRC-1:0]  en_all
);
  logic rd_req;
  logic odd_ofs;
  assign rd_req  = bus_req && !bus_we;
  assign odd_ofs = (bus_addr[5:0] != 6'h10) && (bus_addr[5:0] != 6'h20);

  a_r9_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);
  a_r9_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |=> !bus_rvalid);
  a_r8_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && odd_ofs) |=> (bus_rdata == '0));

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
      localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(32'h10 + 32'h40 * n);
      localparam logic [ADDR_W-1:0] PD_A = ADDR_W'(32'h20 + 32'h40 * n);

      a_r3_enable_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && bus_addr == EN_A) |=> (bus_rdata == $past(en_all[n])));
      a_r4_pending_value: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && bus_addr == PD_A) |=> (bus_rdata == ($past(src_irq) & $past(en_all[n]))));
      a_r7_pending_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == PD_A) |=> $stable(en_all[n]));
      a_r8_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && odd_ofs) |=> $stable(en_all[n]));
      a_r6_empty_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_all[n] == '0) |-> !chan_irq[n]);
      a_r2_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        chan_irq[n] |-> $past(src_irq != '0));
    end
  endgenerate
endmodule

bind irq_fanout_mux irqmux_checker #(
  .NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)
) u_irqmux_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .src_irq    (src_irq),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .chan_irq   (chan_irq),
  .en_all     (en_all)
);

// File: tb/irq_fanout_mux_bench.sv
module irq_fanout_mux_bench;
  localparam int NCH = 6;
  localparam int NS  = 32;
  localparam int AW  = 12;

  logic          clk;
  logic          rst_n;
  logic [NS-1:0] src_irq;
  logic          bus_req;
  logic          bus_we;
  logic [AW-1:0] bus_addr;
  logic [NS-1:0] bus_wdata;
  logic [NS-1:0] bus_rdata;
  logic          bus_rvalid;
  logic [NCH-1:0] chan_irq;

  int errors = 0;
  int checks = 0;
  logic [NS-1:0] en_m [8];

  irq_fanout_mux #(.NUM_CH(NCH), .NUM_SRC(NS), .ADDR_W(AW)) u_irq_fanout_mux (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .chan_irq(chan_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_enable(input logic [AW-1:0] a);
    return a[11:9] == 3'd0 && int'(a[8:6]) < NCH && a[5:0] == 6'h10;
  endfunction

  function automatic logic [NS-1:0] exp_read(input logic [AW-1:0] a);
    if (a[11:9] != 3'd0 || int'(a[8:6]) >= NCH) return '0;
    if (a[5:0] == 6'h10) return en_m[a[8:6]];
    if (a[5:0] == 6'h20) return src_irq & en_m[a[8:6]];
    return '0;
  endfunction

  function automatic logic [NCH-1:0] exp_irq();
    logic [NCH-1:0] r;
    for (int c = 0; c < NCH; c++) r[c] = |(src_irq & en_m[c]);
    return r;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [NS-1:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0;
    chk("R9 write gives no rvalid", 32'(bus_rvalid), 32'd0);
    if (is_enable(a)) en_m[a[8:6]] = d;
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a);
    logic [NS-1:0] e;
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    e = exp_read(a);
    @(negedge clk);
    bus_req = 1'b0;
    chk("R9 read rvalid", 32'(bus_rvalid), 32'd1);
    chk(req, bus_rdata, e);
  endtask

  task automatic set_src(input logic [NS-1:0] v);
    @(negedge clk);
    src_irq = v;
  endtask

  task automatic chk_irq(input string req);
    @(negedge clk);
    chk(req, 32'(chan_irq), 32'(exp_irq()));
  endtask

  function automatic logic [AW-1:0] en_addr(input int c);
    return AW'(12'h10 + 12'h40 * c);
  endfunction
  function automatic logic [AW-1:0] pd_addr(input int c);
    return AW'(12'h20 + 12'h40 * c);
  endfunction

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    for (int c = 0; c < 8; c++) en_m[c] = '0;
    rst_n = 1'b0; src_irq = '0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 outputs low", 32'(chan_irq), 32'd0);
    chk("R1 rvalid low", 32'(bus_rvalid), 32'd0);
    for (int c = 0; c < NCH; c++) rd("R1 enable zero", en_addr(c));
    set_src('1);
    chk_irq("R1 no output with empty masks");

    // R2 fan-out of one source to two channels
    set_src('0);
    wr(en_addr(0), 32'h0000_0001);
    wr(en_addr(3), 32'h0000_0001);
    wr(en_addr(5), 32'h8000_0000);
    set_src(32'h0000_0001);
    #1 chk("R5 output registered, still low", 32'(chan_irq), 32'd0);
    chk_irq("R2 source 0 on channels 0 and 3");
    chk("R2 channel 0 and 3 both high", 32'(chan_irq), 32'b001001);
    // R5 level hold
    repeat (5) chk_irq("R5 output held while level high");
    rd("R3 enable readback ch3", en_addr(3));
    rd("R4 pending ch0", pd_addr(0));
    rd("R4 pending ch5 masked", pd_addr(5));

    // R6 zero write deasserts
    wr(en_addr(3), '0);
    chk_irq("R6 channel 3 deasserted");
    chk("R6 channel 3 low", 32'(chan_irq[3]), 32'd0);

    // R7 pending write ignored
    wr(pd_addr(0), '0);
    rd("R7 enable unchanged after pending write", en_addr(0));
    chk_irq("R7 output unchanged after pending write");

    // R8 unmapped addresses
    wr(12'h014, '1);
    wr(12'h011, '1);
    wr(12'h210, '1);
    rd("R8 unaligned read zero", 12'h011);
    rd("R8 hole read zero", 12'h000);
    rd("R8 high address read zero", 12'h210);
    for (int c = 0; c < NCH; c++) rd("R8 enables untouched", en_addr(c));

    // R10 channel indices at and beyond count
    wr(en_addr(6), '1);
    wr(en_addr(7), '1);
    rd("R10 channel 6 enable reads zero", en_addr(6));
    rd("R10 channel 7 pending reads zero", pd_addr(7));
    chk_irq("R10 no effect on outputs");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      int c;
      logic [AW-1:0] a;
      op = int'($urandom_range(0, 5));
      c  = int'($urandom_range(0, 7));
      case (op)
        0: wr(en_addr(c), $urandom() & $urandom());
        1: wr(pd_addr(c), $urandom());
        2: begin
          a = AW'($urandom());
          wr(a, $urandom());
        end
        3: rd("R3 random enable read", en_addr(c));
        4: rd("R4 random pending read", pd_addr(c));
        default: begin
          a = AW'($urandom_range(0, 1023));
          rd("R8 random address read", a);
        end
      endcase
      if (($urandom() & 3) == 0) set_src($urandom() & $urandom());
      chk_irq("R2 random output match");
    end

    // R6 all masks cleared
    set_src('1);
    for (int c = 0; c < NCH; c++) wr(en_addr(c), '0);
    chk_irq("R6 all cleared");
    chk("R6 all outputs low", 32'(chan_irq), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule